// File: doc/BRIEF.md
# Dual-Port Word Memory with Byte Lanes and Semaphore Flags

This block is a synchronous two-port memory. A left port and a right port each carry active-low chip enable, write strobe, output enable, upper-lane select, lower-lane select and semaphore select, together with an address and write data. Both ports sample their controls on the same clock edge, and both can read or write any word in that cycle. Results appear on the cycle after the edge. The default is 1024 words of two 8-bit lanes. `ADDR_W = 14` gives the full 16K-word size.

A per-port decoder places each access in one of six kinds: ACC_IDLE, ACC_ARR_RD, ACC_ARR_WR, ACC_SEM_RD, ACC_SEM_WR and ACC_BAD. ACC_BAD is an illegal mix of enables. The lane selects choose which half of the word is written or returned. Read lanes that are not driven show a low valid flag and zero data. A per-port block input comes from external busy arbitration and stops that port's array writes.

There are eight semaphore flags in a space of their own, and the low three address bits pick the flag. Each flag is a small state machine with three states: SEM_FREE, SEM_LEFT and SEM_RIGHT. Each port also holds a request bit per flag. Writing data bit 0 = 0 sets the port's request and writing 1 clears it.
- SEM_FREE goes to SEM_LEFT when the left port requests, and to SEM_RIGHT when only the right port requests.
- SEM_LEFT goes to SEM_RIGHT when the left port releases while the right port is waiting. It goes to SEM_FREE when the left port releases and nobody is waiting.
- SEM_RIGHT behaves the same way with the roles of the two ports swapped.

Top module: `dual_port_byte_ram`

## Requirements
- R1: After reset, every port output (read data, both lane valid flags, error) is 0 and all eight semaphore flags are free.
- R2: An array read (chip enable 0, semaphore select 1, write strobe 1, output enable 0) returns, on the next cycle, the stored bits 15:8 with the upper valid flag set when the upper select is 0, and bits 7:0 with the lower valid flag set when the lower select is 0. A lane that is not selected shows valid 0 and data 0.
- R3: An array write (write strobe 0) with only the upper select at 0 changes bits 15:8 and keeps bits 7:0. With only the lower select at 0 it changes bits 7:0 only. With both selects at 0 it changes the whole word.
- R4: With chip enable 0, semaphore select 1 and both lane selects at 1, nothing is read or written.
- R5: With output enable 1, both valid flags are 0 and the read data is 0 on the next cycle, whatever the other controls are.
- R6: With chip enable 1 and semaphore select 1, the port does nothing: no write, no valid lane and no error.
- R7: Chip enable 0, semaphore select 0 and at least one lane select at 0 sets the error output on the next cycle. It changes neither the array nor any semaphore.
- R8: Both ports may write in the same cycle. When they write the same byte lane of the same word and neither is blocked, the left port's data is stored. Different lanes of one word written by the two ports are both stored.
- R9: A port's block input at 1 stops that port's array writes. It has no effect on that port's reads or semaphore writes.
- R10: A read of a word that the other port writes in the same cycle returns the content from before that write.
- R11: A semaphore access needs semaphore select 0 together with either chip enable 1 or both lane selects at 1. A write sets the port's request when data bit 0 is 0 and clears it when bit 0 is 1. A read with output enable 0 returns all sixteen bits 0 if this port owns the flag and all 1 otherwise, with both valid flags set.
- R12: When the owner releases a flag, a waiting request from the other port takes ownership. Requests from both ports in the same cycle on a free flag give the flag to the left port. A waiting port that writes 1 withdraws its request before it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_wr_n | input | 1 | Left write strobe: 0 write, 1 read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_ub_n | input | 1 | Left upper-lane select, active low |
| l_lb_n | input | 1 | Left lower-lane select, active low |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_block | input | 1 | Left array write block from busy arbitration |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_rdata | output | 2*LANE_W | Left read data |
| l_hi_vld | output | 1 | Left upper lane valid |
| l_lo_vld | output | 1 | Left lower lane valid |
| l_err | output | 1 | Left illegal-enable flag |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_wr_n | input | 1 | Right write strobe: 0 write, 1 read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_ub_n | input | 1 | Right upper-lane select, active low |
| r_lb_n | input | 1 | Right lower-lane select, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_block | input | 1 | Right array write block from busy arbitration |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_rdata | output | 2*LANE_W | Right read data |
| r_hi_vld | output | 1 | Right upper lane valid |
| r_lo_vld | output | 1 | Right lower lane valid |
| r_err | output | 1 | Right illegal-enable flag |

## Verification
The bench writes single lanes and then reads back both lanes. A merged or swapped lane shows up as a neighbouring byte that has been overwritten. It drives both ports at the same word to test two cases: left priority, where a reversed order stores the right port's data, and read-during-write, where a design that forwards data returns the new value instead of the old one. It applies the illegal enable mix and the block input, then reads back the array and the flags. A design that leaks these accesses changes the array or a flag. The bench also steps the semaphore through release with a waiting request, through a simultaneous claim and through a withdrawal. A design that got these wrong would grant the flag to the wrong port or leave it stuck.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_ARR_RD,
        ACC_ARR_WR,
        ACC_SEM_RD,
        ACC_SEM_WR,
        ACC_BAD
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEM_FREE,
        SEM_LEFT,
        SEM_RIGHT
    } sem_own_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      hi;
        logic      lo;
        logic      drive;
    } port_cmd_t;
endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
    import dpr_pkg::*;
(
    input  logic      ce_n,
    input  logic      wr_n,
    input  logic      oe_n,
    input  logic      ub_n,
    input  logic      lb_n,
    input  logic      sem_n,
    output port_cmd_t cmd
);
    logic       any_lane;
    logic [2:0] sel;

    assign any_lane = ~ub_n | ~lb_n;
    assign sel      = {sem_n, ce_n, any_lane};

    always_comb begin
        cmd.hi    = ~ub_n;
        cmd.lo    = ~lb_n;
        cmd.drive = ~oe_n;
        unique case (sel)
            3'b001:                 cmd.kind = ACC_BAD;
            3'b000, 3'b010, 3'b011: cmd.kind = wr_n ? ACC_SEM_RD : ACC_SEM_WR;
            3'b101:                 cmd.kind = wr_n ? ACC_ARR_RD : ACC_ARR_WR;
            default:                cmd.kind = ACC_IDLE;
        endcase
    end
endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                     clk,
    input  logic                     l_we,
    input  logic                     l_re,
    input  logic [ADDR_W-1:0]        l_addr,
    input  logic [LANES-1:0]         l_en,
    input  logic [LANES*LANE_W-1:0]  l_wd,
    output logic [LANES*LANE_W-1:0]  l_q,
    input  logic                     r_we,
    input  logic                     r_re,
    input  logic [ADDR_W-1:0]        r_addr,
    input  logic [LANES-1:0]         r_en,
    input  logic [LANES*LANE_W-1:0]  r_wd,
    output logic [LANES*LANE_W-1:0]  r_q
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] lq, rq;

        always_ff @(posedge clk) begin
            if (l_re) lq <= mem[l_addr];
            if (r_re) rq <= mem[r_addr];
            // right first so that the left write wins on a shared word
            if (r_we && r_en[g]) mem[r_addr] <= r_wd[g*LANE_W +: LANE_W];
            if (l_we && l_en[g]) mem[l_addr] <= l_wd[g*LANE_W +: LANE_W];
        end

        assign l_q[g*LANE_W +: LANE_W] = lq;
        assign r_q[g*LANE_W +: LANE_W] = rq;
    end
endmodule

// File: rtl/dpr_sem_bank.sv
module dpr_sem_bank
    import dpr_pkg::*;
#(
    parameter int SEM_N = 8,
    localparam int SEL_W = $clog2(SEM_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_wr,
    input  logic [SEL_W-1:0] l_sel,
    input  logic             l_bit,
    input  logic             r_wr,
    input  logic [SEL_W-1:0] r_sel,
    input  logic             r_bit,
    output logic [SEM_N-1:0] l_val,
    output logic [SEM_N-1:0] r_val
);
    for (genvar i = 0; i < SEM_N; i++) begin : g_flag
        sem_own_e own_q, own_d;
        logic     wl_q, wr_q, wl_d, wr_d;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                own_q <= SEM_FREE;
                wl_q  <= 1'b0;
                wr_q  <= 1'b0;
            end else begin
                own_q <= own_d;
                wl_q  <= wl_d;
                wr_q  <= wr_d;
            end
        end

        always_comb begin
            wl_d  = (l_wr && l_sel == SEL_W'(i)) ? ~l_bit : wl_q;
            wr_d  = (r_wr && r_sel == SEL_W'(i)) ? ~r_bit : wr_q;
            own_d = own_q;
            unique case (own_q)
                SEM_FREE: begin
                    if (wl_d)      own_d = SEM_LEFT;
                    else if (wr_d) own_d = SEM_RIGHT;
                end
                SEM_LEFT: begin
                    if (!wl_d) own_d = wr_d ? SEM_RIGHT : SEM_FREE;
                end
                SEM_RIGHT: begin
                    if (!wr_d) own_d = wl_d ? SEM_LEFT : SEM_FREE;
                end
                default: own_d = SEM_FREE;
            endcase
        end

        assign l_val[i] = (own_q != SEM_LEFT);
        assign r_val[i] = (own_q != SEM_RIGHT);
    end
endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out
    import dpr_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int DATA_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_cmd_t         cmd,
    input  logic              sem_val,
    input  logic [DATA_W-1:0] arr_q,
    output logic [DATA_W-1:0] rdata,
    output logic              hi_vld,
    output logic              lo_vld,
    output logic              err
);
    logic show_hi_q, show_lo_q, show_sem_q, sem_q, err_q;
    logic show_hi_d, show_lo_d, show_sem_d, err_d;

    always_comb begin
        show_hi_d  = 1'b0;
        show_lo_d  = 1'b0;
        show_sem_d = 1'b0;
        err_d      = 1'b0;
        unique case (cmd.kind)
            ACC_ARR_RD: begin
                show_hi_d = cmd.drive & cmd.hi;
                show_lo_d = cmd.drive & cmd.lo;
            end
            ACC_SEM_RD: show_sem_d = cmd.drive;
            ACC_BAD:    err_d      = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            show_hi_q  <= 1'b0;
            show_lo_q  <= 1'b0;
            show_sem_q <= 1'b0;
            sem_q      <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            show_hi_q  <= show_hi_d;
            show_lo_q  <= show_lo_d;
            show_sem_q <= show_sem_d;
            sem_q      <= sem_val;
            err_q      <= err_d;
        end
    end

    always_comb begin
        if (show_sem_q) begin
            rdata = {DATA_W{sem_q}};
        end else begin
            rdata[DATA_W-1:LANE_W] = show_hi_q ? arr_q[DATA_W-1:LANE_W] : '0;
            rdata[LANE_W-1:0]      = show_lo_q ? arr_q[LANE_W-1:0]      : '0;
        end
        hi_vld = show_hi_q | show_sem_q;
        lo_vld = show_lo_q | show_sem_q;
        err    = err_q;
    end
endmodule

// File: rtl/dual_port_byte_ram.sv
module dual_port_byte_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int SEM_N  = 8,
    localparam int DATA_W = 2 * LANE_W,
    localparam int SEL_W  = $clog2(SEM_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_wr_n,
    input  logic              l_oe_n,
    input  logic              l_ub_n,
    input  logic              l_lb_n,
    input  logic              l_sem_n,
    input  logic              l_block,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_hi_vld,
    output logic              l_lo_vld,
    output logic              l_err,
    input  logic              r_ce_n,
    input  logic              r_wr_n,
    input  logic              r_oe_n,
    input  logic              r_ub_n,
    input  logic              r_lb_n,
    input  logic              r_sem_n,
    input  logic              r_block,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_hi_vld,
    output logic              r_lo_vld,
    output logic              r_err
);
    port_cmd_t         l_cmd, r_cmd;
    logic [DATA_W-1:0] l_q, r_q;
    logic [SEM_N-1:0]  l_val, r_val;
    logic [SEL_W-1:0]  l_sel, r_sel;

    assign l_sel = l_addr[SEL_W-1:0];
    assign r_sel = r_addr[SEL_W-1:0];

    dpr_port_decode u_dec_l (
        .ce_n(l_ce_n), .wr_n(l_wr_n), .oe_n(l_oe_n),
        .ub_n(l_ub_n), .lb_n(l_lb_n), .sem_n(l_sem_n), .cmd(l_cmd)
    );

    dpr_port_decode u_dec_r (
        .ce_n(r_ce_n), .wr_n(r_wr_n), .oe_n(r_oe_n),
        .ub_n(r_ub_n), .lb_n(r_lb_n), .sem_n(r_sem_n), .cmd(r_cmd)
    );

    dpr_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(2)) u_array (
        .clk   (clk),
        .l_we  (l_cmd.kind == ACC_ARR_WR && !l_block),
        .l_re  (l_cmd.kind == ACC_ARR_RD),
        .l_addr(l_addr),
        .l_en  ({l_cmd.hi, l_cmd.lo}),
        .l_wd  (l_wdata),
        .l_q   (l_q),
        .r_we  (r_cmd.kind == ACC_ARR_WR && !r_block),
        .r_re  (r_cmd.kind == ACC_ARR_RD),
        .r_addr(r_addr),
        .r_en  ({r_cmd.hi, r_cmd.lo}),
        .r_wd  (r_wdata),
        .r_q   (r_q)
    );

    dpr_sem_bank #(.SEM_N(SEM_N)) u_sem (
        .clk  (clk),
        .rst_n(rst_n),
        .l_wr (l_cmd.kind == ACC_SEM_WR),
        .l_sel(l_sel),
        .l_bit(l_wdata[0]),
        .r_wr (r_cmd.kind == ACC_SEM_WR),
        .r_sel(r_sel),
        .r_bit(r_wdata[0]),
        .l_val(l_val),
        .r_val(r_val)
    );

    dpr_port_out #(.LANE_W(LANE_W)) u_out_l (
        .clk(clk), .rst_n(rst_n), .cmd(l_cmd), .sem_val(l_val[l_sel]),
        .arr_q(l_q), .rdata(l_rdata), .hi_vld(l_hi_vld), .lo_vld(l_lo_vld),
        .err(l_err)
    );

    dpr_port_out #(.LANE_W(LANE_W)) u_out_r (
        .clk(clk), .rst_n(rst_n), .cmd(r_cmd), .sem_val(r_val[r_sel]),
        .arr_q(r_q), .rdata(r_rdata), .hi_vld(r_hi_vld), .lo_vld(r_lo_vld),
        .err(r_err)
    );
endmodule

// File: rtl/dual_port_byte_ram_chk.sv
module dual_port_byte_ram_chk #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    localparam int DATA_W = 2 * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_ce_n, l_wr_n, l_oe_n, l_ub_n, l_lb_n, l_sem_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_hi_vld, l_lo_vld, l_err,
    input logic              r_ce_n, r_wr_n, r_oe_n, r_ub_n, r_lb_n, r_sem_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_hi_vld, r_lo_vld, r_err
);
    AST_OE_OFF_L: assert property (@(posedge clk) disable iff (!rst_n)
        $past(l_oe_n) |-> (!l_hi_vld && !l_lo_vld)); // R5
    AST_OE_OFF_R: assert property (@(posedge clk) disable iff (!rst_n)
        $past(r_oe_n) |-> (!r_hi_vld && !r_lo_vld)); // R5
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(l_ce_n && l_sem_n) |-> (!l_hi_vld && !l_lo_vld && !l_err)); // R6
    AST_NO_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!l_ce_n && l_sem_n && l_ub_n && l_lb_n) |-> (!l_hi_vld && !l_lo_vld)); // R4
    AST_ERR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (l_err || r_err) |-> !(l_err && (l_hi_vld || l_lo_vld)) && !(r_err && (r_hi_vld || r_lo_vld))); // R7
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !l_hi_vld |-> (l_rdata[DATA_W-1:LANE_W] == '0)); // R2
    AST_SEM_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!l_sem_n && !r_sem_n && l_wr_n && r_wr_n && !l_oe_n && !r_oe_n &&
              (l_ce_n || (l_ub_n && l_lb_n)) && (r_ce_n || (r_ub_n && r_lb_n)) &&
              l_addr[2:0] == r_addr[2:0])
        |-> !(l_rdata[0] == 1'b0 && r_rdata[0] == 1'b0)); // R11
endmodule

bind dual_port_byte_ram dual_port_byte_ram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_ub_n(l_ub_n),
    .l_lb_n(l_lb_n), .l_sem_n(l_sem_n), .l_addr(l_addr), .l_rdata(l_rdata),
    .l_hi_vld(l_hi_vld), .l_lo_vld(l_lo_vld), .l_err(l_err),
    .r_ce_n(r_ce_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_ub_n(r_ub_n),
    .r_lb_n(r_lb_n), .r_sem_n(r_sem_n), .r_addr(r_addr), .r_rdata(r_rdata),
    .r_hi_vld(r_hi_vld), .r_lo_vld(r_lo_vld), .r_err(r_err)
);

// File: tb/sim_dual_port_byte_ram.sv
module sim_dual_port_byte_ram;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        p_ce[2], p_wr[2], p_oe[2], p_ub[2], p_lb[2], p_sem[2], p_blk[2];
    logic [9:0]  p_addr[2];
    logic [15:0] p_wd[2];
    logic [15:0] l_rdata, r_rdata;
    logic        l_hi_vld, l_lo_vld, l_err, r_hi_vld, r_lo_vld, r_err;

    dual_port_byte_ram #(.ADDR_W(10), .LANE_W(8), .SEM_N(8)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(p_ce[0]), .l_wr_n(p_wr[0]), .l_oe_n(p_oe[0]), .l_ub_n(p_ub[0]),
        .l_lb_n(p_lb[0]), .l_sem_n(p_sem[0]), .l_block(p_blk[0]),
        .l_addr(p_addr[0]), .l_wdata(p_wd[0]),
        .l_rdata(l_rdata), .l_hi_vld(l_hi_vld), .l_lo_vld(l_lo_vld), .l_err(l_err),
        .r_ce_n(p_ce[1]), .r_wr_n(p_wr[1]), .r_oe_n(p_oe[1]), .r_ub_n(p_ub[1]),
        .r_lb_n(p_lb[1]), .r_sem_n(p_sem[1]), .r_block(p_blk[1]),
        .r_addr(p_addr[1]), .r_wdata(p_wd[1]),
        .r_rdata(r_rdata), .r_hi_vld(r_hi_vld), .r_lo_vld(r_lo_vld), .r_err(r_err)
    );

    // behavioural reference
    logic [15:0] m_mem[1024];
    int          m_own[8];      // 0 free, 1 left, 2 right
    bit          m_want[2][8];
    logic [15:0] e_data[2];
    logic        e_hv[2], e_lv[2], e_err[2];

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;

    task automatic idle_all();
        for (int p = 0; p < 2; p++) begin
            p_ce[p] = 1; p_wr[p] = 1; p_oe[p] = 1; p_ub[p] = 1; p_lb[p] = 1;
            p_sem[p] = 1; p_blk[p] = 0; p_addr[p] = '0; p_wd[p] = '0;
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_own[i] = 0; m_want[0][i] = 0; m_want[1][i] = 0;
        end
        for (int p = 0; p < 2; p++) begin
            e_data[p] = '0; e_hv[p] = 0; e_lv[p] = 0; e_err[p] = 0;
        end
    endtask

    task automatic model_step();
        bit any, bad, semacc, arr;
        int a3;
        for (int p = 0; p < 2; p++) begin
            any    = !p_ub[p] || !p_lb[p];
            bad    = !p_sem[p] && !p_ce[p] && any;
            semacc = !p_sem[p] && !bad;
            arr    = p_sem[p] && !p_ce[p] && any;
            a3     = int'(p_addr[p][2:0]);
            e_err[p] = bad; e_hv[p] = 0; e_lv[p] = 0; e_data[p] = '0;
            if (semacc && p_wr[p] && !p_oe[p]) begin
                e_hv[p] = 1; e_lv[p] = 1;
                e_data[p] = (m_own[a3] == p + 1) ? 16'h0000 : 16'hFFFF;
            end else if (arr && p_wr[p] && !p_oe[p]) begin
                e_hv[p] = !p_ub[p]; e_lv[p] = !p_lb[p];
                if (e_hv[p]) e_data[p][15:8] = m_mem[p_addr[p]][15:8];
                if (e_lv[p]) e_data[p][7:0]  = m_mem[p_addr[p]][7:0];
            end
        end
        for (int p = 1; p >= 0; p--) begin
            arr = p_sem[p] && !p_ce[p] && (!p_ub[p] || !p_lb[p]);
            if (arr && !p_wr[p] && !p_blk[p]) begin
                if (!p_ub[p]) m_mem[p_addr[p]][15:8] = p_wd[p][15:8];
                if (!p_lb[p]) m_mem[p_addr[p]][7:0]  = p_wd[p][7:0];
            end
            semacc = !p_sem[p] && (p_ce[p] || (p_ub[p] && p_lb[p]));
            if (semacc && !p_wr[p]) m_want[p][p_addr[p][2:0]] = !p_wd[p][0];
        end
        for (int i = 0; i < 8; i++) begin
            case (m_own[i])
                0: m_own[i] = m_want[0][i] ? 1 : (m_want[1][i] ? 2 : 0);
                1: if (!m_want[0][i]) m_own[i] = m_want[1][i] ? 2 : 0;
                default: if (!m_want[1][i]) m_own[i] = m_want[0][i] ? 1 : 0;
            endcase
        end
    endtask

    task automatic compare(string tag);
        logic [15:0] ad[2];
        logic        ah[2], al[2], ae[2];
        ad[0] = l_rdata; ah[0] = l_hi_vld; al[0] = l_lo_vld; ae[0] = l_err;
        ad[1] = r_rdata; ah[1] = r_hi_vld; al[1] = r_lo_vld; ae[1] = r_err;
        for (int p = 0; p < 2; p++) begin
            n_vec++;
            if (ad[p] !== e_data[p] || ah[p] !== e_hv[p] || al[p] !== e_lv[p] || ae[p] !== e_err[p]) begin
                n_bad++;
                $display("FAIL %s port%0d: actual data=%h hv=%b lv=%b err=%b expected data=%h hv=%b lv=%b err=%b",
                         tag, p, ad[p], ah[p], al[p], ae[p], e_data[p], e_hv[p], e_lv[p], e_err[p]);
            end
        end
    endtask

    // apply the current stimulus for one edge, then check
    task automatic step(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        idle_all();
    endtask

    task automatic arr_op(int p, bit wr, bit ub, bit lb, int a, logic [15:0] d);
        p_ce[p] = 0; p_sem[p] = 1; p_wr[p] = !wr; p_oe[p] = wr;
        p_ub[p] = !ub; p_lb[p] = !lb; p_addr[p] = 10'(a); p_wd[p] = d;
    endtask

    task automatic sem_op(int p, bit wr, int a, bit b);
        p_ce[p] = 1; p_sem[p] = 0; p_wr[p] = !wr; p_oe[p] = wr;
        p_addr[p] = 10'(a); p_wd[p] = {15'h0, b};
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        idle_all();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare("R1 reset outputs");
        for (int i = 0; i < 8; i++) begin
            sem_op(0, 0, i, 0); step("R1 flags free");
        end

        // R3 lane writes
        arr_op(0, 1, 1, 1, 5, 16'h1234); step("R3");
        arr_op(0, 1, 1, 0, 5, 16'hABCD); step("R3");
        arr_op(1, 0, 1, 1, 5, 16'h0);    step("R3 upper only");
        arr_op(1, 1, 0, 1, 5, 16'h5566); step("R3");
        arr_op(0, 0, 1, 1, 5, 16'h0);    step("R3 lower only");
        // R2 lane reads
        arr_op(0, 1, 1, 1, 9, 16'hC3A5); step("R2");
        arr_op(0, 0, 1, 0, 9, 16'h0);    step("R2 upper lane");
        arr_op(1, 0, 0, 1, 9, 16'h0);    step("R2 lower lane");
        // R4 no lane select
        arr_op(0, 1, 0, 0, 9, 16'hFFFF); step("R4 write");
        arr_op(0, 0, 0, 0, 9, 16'h0);    step("R4 read");
        arr_op(0, 0, 1, 1, 9, 16'h0);    step("R4 readback");
        // R5 output enable off
        arr_op(1, 0, 1, 1, 9, 16'h0); p_oe[1] = 1; step("R5");
        // R6 deselect
        arr_op(0, 1, 1, 1, 9, 16'h7777); p_ce[0] = 1; step("R6 write");
        arr_op(0, 0, 1, 1, 9, 16'h0);    step("R6 readback");
        // R7 illegal mix
        arr_op(0, 1, 1, 0, 9, 16'h0000); p_sem[0] = 0; step("R7 err");
        arr_op(1, 0, 1, 1, 9, 16'h0);    step("R7 array kept");
        sem_op(0, 0, 0, 0);              step("R7 flag kept");
        // R8 simultaneous writes
        arr_op(0, 1, 1, 1, 20, 16'hAAAA); arr_op(1, 1, 1, 1, 20, 16'h5555); step("R8 same word");
        arr_op(0, 0, 1, 1, 20, 16'h0); step("R8 left wins");
        arr_op(0, 1, 1, 0, 21, 16'h1100); arr_op(1, 1, 0, 1, 21, 16'h0022); step("R8 lanes");
        arr_op(1, 0, 1, 1, 21, 16'h0); step("R8 merge");
        // R9 block
        arr_op(0, 1, 1, 1, 20, 16'hDEAD); p_blk[0] = 1; step("R9 blocked write");
        arr_op(0, 0, 1, 1, 20, 16'h0); p_blk[0] = 1; step("R9 read while blocked");
        sem_op(1, 1, 2, 0); p_blk[1] = 1; step("R9 sem write");
        sem_op(1, 0, 2, 0); step("R9 sem owned");
        sem_op(1, 1, 2, 1); step("R9 release");
        // R10 read during write
        arr_op(0, 1, 1, 1, 30, 16'h1111); step("R10 init");
        arr_op(0, 1, 1, 1, 30, 16'h2222); arr_op(1, 0, 1, 1, 30, 16'h0); step("R10 old data");
        arr_op(1, 0, 1, 1, 30, 16'h0); step("R10 new data");
        // R11 semaphore claim, both sides read, alternate select form
        sem_op(0, 1, 3, 0); step("R11 claim");
        sem_op(0, 0, 3, 0); sem_op(1, 0, 3, 0); step("R11 owner view");
        sem_op(1, 0, 11, 0); p_ce[1] = 0; step("R11 ce low form");
        // R12 handover, priority, withdrawal
        sem_op(1, 1, 3, 0); step("R12 wait");
        sem_op(1, 0, 3, 0); step("R12 still waiting");
        sem_op(0, 1, 3, 1); step("R12 release");
        sem_op(0, 0, 3, 0); sem_op(1, 0, 3, 0); step("R12 granted");
        sem_op(1, 1, 3, 1); step("R12 free");
        sem_op(0, 1, 6, 0); sem_op(1, 1, 6, 0); step("R12 tie");
        sem_op(0, 0, 6, 0); sem_op(1, 0, 6, 0); step("R12 left first");
        sem_op(1, 1, 6, 1); step("R12 withdraw");
        sem_op(0, 1, 6, 1); step("R12 release");
        sem_op(1, 0, 6, 0); sem_op(0, 0, 6, 0); step("R12 none granted");

        // mixed traffic on a prefilled window
        for (int a = 0; a < 64; a++) begin
            arr_op(0, 1, 1, 1, a, 16'(a * 16'h0101 + 7)); step("R3 fill");
        end
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            for (int p = 0; p < 2; p++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                p_ce[p] = lfsr[0]; p_wr[p] = lfsr[1]; p_oe[p] = lfsr[2] & lfsr[3];
                p_ub[p] = lfsr[4]; p_lb[p] = lfsr[5]; p_sem[p] = lfsr[6] | lfsr[7];
                p_blk[p] = lfsr[8] & lfsr[9];
                p_addr[p] = {4'h0, lfsr[15:10]};
                p_wd[p] = {lfsr[7:0], lfsr[15:8]};
            end
            step("R8 mixed");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule